// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block is the host side of a four-wire serial link to an 8-bit voltage-output converter. A parallel request selects one of two targets: the output code register or the control register. It also carries a speed flag, a power-down flag, an 8-bit code and a 2-bit reference selection. The block builds the 16-bit command word from these fields. It then drives chip select, frame sync, serial clock and data, with every edge placed by countdown timers that run on the system clock. The parameter `HALF` sets the number of system clocks in each serial clock phase, and the same count sets every setup and hold interval on the link.

A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low until every frame for that request has gone out. `done` pulses once per frame, in the cycle after chip select goes high. When `auto_ctrl` is set, a code write is preceded by a control write that carries the requested configuration. This extra frame is sent only if no control frame has been sent since reset, or if the reference, speed or power-down setting differs from the last control frame sent. When `byte_mode` is set, each 16-bit word goes out as two 8-bit bursts under one frame sync, which matches the behaviour of a byte-wide host.

Top module: `dac_serial_master`

## Requirements
- R1: In reset and when idle, `cs_n`, `fs` and `sclk` are all high, `req_ready` is high and `done` is low.
- R2: A control frame carries, from bit 15 down to bit 12: 1, the speed flag, the power-down flag, 1. Bits 1..0 hold the reference selection and every other bit is 0. For example, fast mode with selection 2 gives 0xD002.
- R3: A code frame carries, from bit 15 down to bit 12: 0, the speed flag, the power-down flag, 0. The code sits in bits 11..4 and bits 3..0 are 0. Every frame is shifted out most significant bit first.
- R4: Each frame has exactly 16 falling `sclk` edges. `cs_n` falls at least `HALF` clocks before `fs` falls. `fs` falls at least `HALF` clocks before the first falling edge. `sdo` changes only while `sclk` is high. `fs` rises at least `HALF` clocks after the 16th falling edge. `cs_n` rises at least `HALF` clocks after the last rising edge of `sclk`.
- R5: When `auto_ctrl` is high and a code write is requested, a control frame carrying the requested reference, speed and power-down settings goes out first. This happens if no control frame has been sent since reset, or if any of these settings differs from the last control frame sent.
- R6: When `auto_ctrl` is high and the settings match the last control frame sent, only the code frame goes out. When `auto_ctrl` is low, only the requested frame goes out.
- R7: With `byte_mode` high, the word is still 16 bits under one low `fs`. The interval between the 8th and 9th falling edges is `4*HALF` clocks, while the other intervals are `2*HALF` clocks.
- R8: `req_ready` is low from acceptance until the last frame of the request has finished. Requests and field changes made while the block is busy have no effect.
- R9: `done` is a one-cycle pulse, raised once per frame in the first cycle `cs_n` is high after that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_ctrl | input | 1 | 1 selects the control register, 0 selects the code register |
| req_fast | input | 1 | Speed flag |
| req_pdown | input | 1 | Power-down flag |
| req_code | input | 8 | Output code |
| req_ref | input | 2 | Reference selection |
| auto_ctrl | input | 1 | Send a control frame ahead of a code write when the settings are stale |
| byte_mode | input | 1 | Split each word into two 8-bit bursts |
| done | output | 1 | One pulse per finished frame |
| cs_n | output | 1 | Chip select, active low |
| fs | output | 1 | Frame sync, falls to open a frame |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, most significant bit first |

## Verification
The bench sweeps all 256 codes with rotating flag pairs and decodes each frame from the pins. A wrong bit position or bit order would show up as a wrong word. Every frame is also timed from the pins: data that moves while the clock is low, a 15th or 17th edge, or frame sync rising too soon after the last bit would each flag a timing violation. The auto-control path is tested right after a reset, with matching settings and with each setting changed on its own. A design that skipped the control frame after a reset, or compared only some of the fields, would produce the wrong number of frames. Byte mode must show the longer interval between the 8th and 9th falling edges, and junk requests made while busy must not change what goes on the wire.

// File: rtl/dac_serial_master.sv
module dac_serial_master #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_ctrl,
  input  logic       req_fast,
  input  logic       req_pdown,
  input  logic [7:0] req_code,
  input  logic [1:0] req_ref,
  input  logic       auto_ctrl,
  input  logic       byte_mode,
  output logic       done,
  output logic       cs_n,
  output logic       fs,
  output logic       sclk,
  output logic       sdo
);
  localparam int CW = $clog2(2*HALF+1);
  localparam logic [CW-1:0] HL = CW'(HALF-1);
  localparam logic [CW-1:0] PL = CW'(2*HALF-1);

  typedef enum logic [3:0] {S_IDLE, S_CSL, S_FSL, S_LO, S_HI, S_PAUSE, S_FSH, S_FIN, S_GAP} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0] nbit;
  logic [15:0] sh, dword;
  logic pend, is_ctrl, bmode;
  logic cfg_ok, last_fast, last_pd;
  logic [1:0] last_ref;
  logic fast_q, pd_q;
  logic [1:0] ref_q;

  wire [15:0] ctrl_w = {1'b1, req_fast, req_pdown, 1'b1, 10'd0, req_ref};
  wire [15:0] data_w = {1'b0, req_fast, req_pdown, 1'b0, req_code, 4'd0};
  wire stale = !cfg_ok || last_ref != req_ref || last_fast != req_fast || last_pd != req_pdown;
  wire need_ctrl = auto_ctrl && !req_ctrl && stale;
  wire tick = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; nbit <= '0; sh <= '0; dword <= '0;
      pend <= 1'b0; is_ctrl <= 1'b0; bmode <= 1'b0;
      cfg_ok <= 1'b0; last_fast <= 1'b0; last_pd <= 1'b0; last_ref <= '0;
      fast_q <= 1'b0; pd_q <= 1'b0; ref_q <= '0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          sh      <= (req_ctrl || need_ctrl) ? ctrl_w : data_w;
          dword   <= data_w;
          pend    <= need_ctrl;
          is_ctrl <= req_ctrl || need_ctrl;
          bmode   <= byte_mode;
          fast_q  <= req_fast; pd_q <= req_pdown; ref_q <= req_ref;
          st <= S_CSL; cnt <= HL;
        end
        S_CSL: if (tick) begin st <= S_FSL; cnt <= HL; nbit <= '0; end
        S_FSL: if (tick) begin st <= S_LO; cnt <= HL; end
        S_LO:  if (tick) begin st <= S_HI; cnt <= HL; sh <= {sh[14:0], 1'b0}; end
        S_HI:  if (tick) begin
          if (nbit == 4'd15) begin
            st <= S_FSH; cnt <= HL;
          end else if (bmode && nbit == 4'd7) begin
            st <= S_PAUSE; cnt <= PL; nbit <= nbit + 4'd1;
          end else begin
            st <= S_LO; cnt <= HL; nbit <= nbit + 4'd1;
          end
        end
        S_PAUSE: if (tick) begin st <= S_LO; cnt <= HL; end
        S_FSH:   if (tick) st <= S_FIN;
        S_FIN: begin
          if (is_ctrl) begin
            cfg_ok <= 1'b1; last_fast <= fast_q; last_pd <= pd_q; last_ref <= ref_q;
          end
          if (pend) begin
            sh <= dword; pend <= 1'b0; is_ctrl <= 1'b0;
            st <= S_GAP; cnt <= HL;
          end else begin
            st <= S_IDLE;
          end
        end
        S_GAP: if (tick) begin st <= S_CSL; cnt <= HL; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign cs_n      = (st == S_IDLE) || (st == S_FIN) || (st == S_GAP);
  assign fs        = cs_n || (st == S_CSL) || (st == S_FSH);
  assign sclk      = (st != S_LO);
  assign sdo       = sh[15];

  logic sclk_q;
  logic [4:0] nfall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1; nfall <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) nfall <= '0;
      else if (sclk_q && !sclk) nfall <= nfall + 5'd1;
    end
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> (fs && sclk)); // R1
  AST_FS_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) !fs |-> !cs_n); // R4
  AST_SDO_STILL_LOW: assert property (@(posedge clk) disable iff (!rst_n) (!sclk && !sclk_q) |-> $stable(sdo)); // R4
  AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n) done |-> nfall == 5'd16); // R4
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cs_n && !$past(cs_n))); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (cs_n && !done)); // R8
endmodule

// File: tb/dac_serial_master_tb.sv
module dac_serial_master_tb;
  localparam int HALF = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ctrl = 1'b0, req_fast = 1'b0, req_pdown = 1'b0;
  logic [7:0] req_code = '0;
  logic [1:0] req_ref = '0;
  logic auto_ctrl = 1'b0, byte_mode = 1'b0;
  logic req_ready, done, cs_n, fs, sclk, sdo;

  dac_serial_master #(.HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ctrl(req_ctrl), .req_fast(req_fast), .req_pdown(req_pdown),
    .req_code(req_code), .req_ref(req_ref), .auto_ctrl(auto_ctrl),
    .byte_mode(byte_mode), .done(done), .cs_n(cs_n), .fs(fs), .sclk(sclk), .sdo(sdo));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0, nfr = 0, ndone = 0, done_bad = 0;
  int nb = 0, t_csf = 0, t_fsf = 0, t_fsr = 0, t_lr = 0;
  int fall_t [16];
  bit viol = 0;
  logic pcs = 1'b1, pfs = 1'b1, psclk = 1'b1, psdo = 1'b0;
  logic [15:0] cw = '0;
  logic [15:0] cap [8];
  bit cap_v [8];
  int g78 [8];
  int g01 [8];

  always @(negedge clk) begin
    cyc++;
    if (pcs && !cs_n) begin t_csf = cyc; nb = 0; cw = '0; viol = 0; end
    if (pfs && !fs) t_fsf = cyc;
    if (psclk && !sclk && !cs_n) begin
      if (nb < 16) fall_t[nb] = cyc;
      cw = {cw[14:0], sdo};
      nb++;
    end
    if (!psclk && sclk && !cs_n) t_lr = cyc;
    if (!psclk && !sclk && sdo != psdo) viol = 1;
    if (!pfs && fs && !cs_n) t_fsr = cyc;
    if (!pcs && cs_n) begin
      if (nb != 16) viol = 1;
      else begin
        if (t_fsf - t_csf < HALF) viol = 1;
        if (fall_t[0] - t_fsf < HALF) viol = 1;
        if (t_fsr - fall_t[15] < HALF) viol = 1;
        if (cyc - t_lr < HALF) viol = 1;
        g78[nfr % 8] = fall_t[8] - fall_t[7];
        g01[nfr % 8] = fall_t[1] - fall_t[0];
      end
      cap[nfr % 8] = cw;
      cap_v[nfr % 8] = viol;
      nfr++;
    end
    if (done) begin ndone++; if (!cs_n) done_bad++; end
    pcs = cs_n; pfs = fs; psclk = sclk; psdo = sdo;
  end

  bit mok = 0, mfast = 0, mpd = 0;
  logic [1:0] mref = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && fs && sclk && req_ready && !done, "R1 levels in reset",
        {cs_n, fs, sclk, req_ready, done}, 5'b11110);
    rst_n = 1'b1;
    mok = 0;
    @(negedge clk);
    chk(cs_n && fs && sclk && req_ready && !done, "R1 idle levels",
        {cs_n, fs, sclk, req_ready, done}, 5'b11110);
  endtask

  task automatic send(input bit c, input bit f, input bit p, input logic [7:0] code,
                      input logic [1:0] rf, input bit au, input bit bm, input bit junk,
                      input string tag);
    logic [15:0] cwd, dwd, e0, e1;
    bit needc;
    int en, base, bd;
    cwd = {1'b1, f, p, 1'b1, 10'd0, rf};
    dwd = {1'b0, f, p, 1'b0, code, 4'd0};
    needc = au && !c && (!mok || mref != rf || mfast != f || mpd != p);
    if (c) begin en = 1; e0 = cwd; e1 = cwd; end
    else if (needc) begin en = 2; e0 = cwd; e1 = dwd; end
    else begin en = 1; e0 = dwd; e1 = dwd; end
    if (c || needc) begin mok = 1; mref = rf; mfast = f; mpd = p; end
    base = nfr; bd = ndone;
    req_ctrl = c; req_fast = f; req_pdown = p; req_code = code; req_ref = rf;
    auto_ctrl = au; byte_mode = bm; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready low after accept", req_ready, 0);
    if (junk) begin
      for (int k = 0; k < 20; k++) begin
        req_valid = 1'b1; req_ctrl = ~c; req_code = ~code; req_ref = ~rf;
        req_fast = ~f; byte_mode = ~bm;
        @(negedge clk);
        chk(!req_ready, "R8 ready low while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!req_ready) @(negedge clk);
    chk(nfr - base == en, {tag, " frame count"}, nfr - base, en);
    chk(ndone - bd == en && done_bad == 0, "R9 done pulses", ndone - bd, en);
    if (nfr - base == en) begin
      chk(cap[base % 8] == e0, {tag, " first word"}, cap[base % 8], e0);
      chk(!cap_v[base % 8], "R4 timing first frame", cap_v[base % 8], 0);
      if (en == 2) begin
        chk(cap[(base + 1) % 8] == e1, {tag, " second word"}, cap[(base + 1) % 8], e1);
        chk(!cap_v[(base + 1) % 8], "R4 timing second frame", cap_v[(base + 1) % 8], 0);
      end
      for (int k = 0; k < en; k++) begin
        chk(g01[(base + k) % 8] == 2*HALF, "R7 normal edge interval", g01[(base + k) % 8], 2*HALF);
        chk(g78[(base + k) % 8] == (bm ? 4*HALF : 2*HALF), "R7 mid-word interval",
            g78[(base + k) % 8], bm ? 4*HALF : 2*HALF);
      end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    send(1, 1, 0, 8'h00, 2'd2, 0, 0, 0, "R2 control 0xD002");
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 4; m++)
        send(1, m[0], m[1], 8'hA5, r[1:0], 0, 0, 0, "R2 control sweep");
    for (int c = 0; c < 256; c++)
      send(0, c[0], c[1], c[7:0], 2'd0, 0, 0, 0, "R3 code sweep");
    send(0, 1, 0, 8'h80, 2'd1, 0, 0, 0, "R6 auto off only code");
    do_reset();
    send(0, 1, 0, 8'h3C, 2'd2, 1, 0, 0, "R5 auto after reset");
    send(0, 1, 0, 8'hC3, 2'd2, 1, 0, 0, "R6 auto same settings");
    send(0, 1, 1, 8'h11, 2'd2, 1, 0, 0, "R5 auto power change");
    send(0, 0, 1, 8'h22, 2'd2, 1, 0, 0, "R5 auto speed change");
    send(0, 0, 1, 8'h33, 2'd1, 1, 0, 0, "R5 auto ref change");
    send(0, 0, 1, 8'h44, 2'd1, 1, 0, 0, "R6 auto repeat");
    send(0, 1, 0, 8'h5A, 2'd3, 1, 1, 0, "R7 byte mode with auto");
    send(0, 1, 0, 8'hA5, 2'd3, 0, 1, 0, "R7 byte mode code");
    send(1, 0, 0, 8'h00, 2'd1, 0, 1, 0, "R7 byte mode control");
    send(0, 1, 1, 8'h69, 2'd0, 0, 0, 1, "R8 junk while busy");
    send(0, 0, 1, 8'h96, 2'd1, 1, 1, 1, "R8 junk during two frames");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule